// File: doc/BRIEF.md
# Two-Level Translation Entry Lookup

This block holds the tags of a translation buffer split into two structures and answers, one cycle after a request, whether a virtual address is mapped and at which entry. The larger structure is set-associative: a single page size, given by a global input, picks both the set index and the compared bits for all of its entries. The smaller structure is fully associative, and every entry in it keeps its own page size. Each entry covers an aligned pair of neighbouring pages (an even and an odd page), so the bit just above the page offset is never compared.

A request carries a virtual address and the address-space identifier of the running context. An entry matches when it is enabled, its stored page-pair number agrees with the address above the pair boundary, and it is either marked global or tagged with the same identifier. The set-associative ways are searched before the fully associative slots, and inside each structure the lowest numbered candidate wins. Entries are written through a fill port that names the target index directly, and an entry can be disabled through a clear port. Permission checks and replacement choice belong to the surrounding logic.

Top module: `tlb_hybrid_lookup`

## Requirements
- R1: A response appears exactly one clock after each request: `rsp_valid` is high in the cycle after `req_valid` was high and low otherwise.
- R2: Reset (synchronous, active high) disables every entry and clears `rsp_valid`, `rsp_hit` and `rsp_idx`; a lookup after reset misses.
- R3: The set-associative set is the low 8 bits of `req_va >> (glb_ps + 1)`, and a hit there reports `rsp_idx = way*256 + set` (8 ways, 256 sets, indices 0 to 2047).
- R4: An entry matches when the address bits from `ps + 1` upward equal the same bits of `{vppn, 13'b0}`; both pages of the pair (bit `ps` either value) hit the same entry.
- R5: A tag comparison only counts when the entry is global or its stored ASID equals `req_asid`.
- R6: All set-associative ways take priority over the fully associative slots; the lowest way, and then the lowest slot, wins among several hits.
- R7: Fully associative entries compare with their own stored page size; `glb_ps` does not affect them.
- R8: A fill at index below 2048 writes way `idx[10:8]`, set `idx[7:0]`; a fill at index 2048 to 2055 writes slot `idx - 2048`. A fill stores the page-pair number, the ASID, the global flag and enables the entry; `fill_ps` is kept only by fully associative slots.
- R9: A clear at an index disables that entry, so later lookups skip it.
- R10: On a miss `rsp_hit` is low and `rsp_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 48 | Virtual address to translate |
| req_asid | input | 10 | Identifier of the current address space |
| glb_ps | input | 6 | Page size (log2) for the set-associative structure |
| fill_en | input | 1 | Write one entry |
| fill_idx | input | 12 | Target entry index |
| fill_vppn | input | 35 | Address bits 47 to 13 of the page pair |
| fill_asid | input | 10 | Identifier stored with the entry |
| fill_glb | input | 1 | Entry is global (matches any identifier) |
| fill_ps | input | 6 | Page size (log2) for a fully associative slot |
| clr_en | input | 1 | Disable one entry |
| clr_idx | input | 12 | Index of the entry to disable |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Address matched an entry |
| rsp_idx | output | 12 | Index of the winning entry, 0 on a miss |

## Verification
A wrong enable bit, a stale tag or a misdecoded fill index shows up as a wrong `rsp_hit` or `rsp_idx` on the very next lookup that reaches the affected set or slot, one cycle after the request. A broken priority chain is exposed only when two entries cover the same address, so the stimulus deliberately stacks duplicates across ways and across both structures and removes them one by one. A wrong set computation appears as a reported index whose low bits disagree with the requested address, which the checker flags on the response cycle.

// File: rtl/tlb_hyb_pkg.sv
package tlb_hyb_pkg;

    localparam int VA_W     = 48;
    localparam int PAIR_LSB = 13;
    localparam int VPPN_W   = VA_W - PAIR_LSB;
    localparam int ASID_W   = 10;
    localparam int PS_W     = 6;

    typedef struct packed {
        logic [VPPN_W-1:0] vppn;
        logic [ASID_W-1:0] asid;
        logic              glb;
    } tag_t;

    // bits of an address at and above the pair boundary for page size ps
    function automatic logic [VA_W-1:0] pair_mask(input logic [PS_W-1:0] ps);
        return {VA_W{1'b1}} << ({1'b0, ps} + 7'd1);
    endfunction

    function automatic logic tag_match(input tag_t t,
                                       input logic [VA_W-1:0] va,
                                       input logic [ASID_W-1:0] asid,
                                       input logic [PS_W-1:0] ps);
        logic [VA_W-1:0] keep;
        logic [VA_W-1:0] base;
        keep = pair_mask(ps);
        base = {t.vppn, {PAIR_LSB{1'b0}}};
        return ((va & keep) == (base & keep)) && (t.glb || (t.asid == asid));
    endfunction

endpackage

// File: rtl/tlb_sa_bank.sv
module tlb_sa_bank
    import tlb_hyb_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 256,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [PS_W-1:0]   glb_ps,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  tag_t              wr_tag,
    input  logic              clr_en,
    input  logic [WAY_W-1:0]  clr_way,
    input  logic [SET_W-1:0]  clr_set,
    output logic [SET_W-1:0]  lk_set,
    output logic [WAYS-1:0]   way_hit
);

    assign lk_set = SET_W'(lk_va >> ({1'b0, glb_ps} + 7'd1));

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tag_t             tag_mem [SETS];
        logic [SETS-1:0]  en_q;
        logic             wr_here;
        logic             clr_here;

        assign wr_here  = wr_en  && (wr_way  == WAY_W'(w));
        assign clr_here = clr_en && (clr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q <= '0;
            end else begin
                if (clr_here) en_q[clr_set] <= 1'b0;
                if (wr_here)  en_q[wr_set]  <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_here) tag_mem[wr_set] <= wr_tag;
        end

        assign way_hit[w] = en_q[lk_set] &&
                            tag_match(tag_mem[lk_set], lk_va, lk_asid, glb_ps);
    end

endmodule

// File: rtl/tlb_fa_bank.sv
module tlb_fa_bank
    import tlb_hyb_pkg::*;
#(
    parameter int FA_N = 8,
    localparam int FA_W = (FA_N > 1) ? $clog2(FA_N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              wr_en,
    input  logic [FA_W-1:0]   wr_slot,
    input  tag_t              wr_tag,
    input  logic [PS_W-1:0]   wr_ps,
    input  logic              clr_en,
    input  logic [FA_W-1:0]   clr_slot,
    output logic [FA_N-1:0]   slot_hit
);

    for (genvar i = 0; i < FA_N; i++) begin : g_slot
        tag_t            tag_q;
        logic [PS_W-1:0] ps_q;
        logic            en_q;
        logic            wr_here;

        assign wr_here = wr_en && (wr_slot == FA_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q <= 1'b0;
            end else begin
                if (clr_en && (clr_slot == FA_W'(i))) en_q <= 1'b0;
                if (wr_here)                          en_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_here) begin
                tag_q <= wr_tag;
                ps_q  <= wr_ps;
            end
        end

        assign slot_hit[i] = en_q && tag_match(tag_q, lk_va, lk_asid, ps_q);
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int WAYS  = 8,
    parameter int SETS  = 256,
    parameter int FA_N  = 8,
    localparam int SET_W  = $clog2(SETS),
    localparam int SA_ENT = WAYS * SETS,
    localparam int IDX_W  = $clog2(SA_ENT + FA_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [SET_W-1:0] lk_set,
    input  logic [WAYS-1:0]  way_hit,
    input  logic [FA_N-1:0]  slot_hit,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_idx
);

    logic             hit_n;
    logic [IDX_W-1:0] idx_n;

    // scan from the top down so the lowest candidate is written last
    always_comb begin
        hit_n = 1'b0;
        idx_n = '0;
        for (int i = FA_N - 1; i >= 0; i--) begin
            if (slot_hit[i]) begin
                hit_n = 1'b1;
                idx_n = IDX_W'(SA_ENT + i);
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit_n = 1'b1;
                idx_n = (IDX_W'(w) << SET_W) | IDX_W'(lk_set);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && hit_n;
            rsp_idx   <= (req_valid && hit_n) ? idx_n : '0;
        end
    end

endmodule

// File: rtl/tlb_hybrid_lookup.sv
module tlb_hybrid_lookup
    import tlb_hyb_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 256,
    parameter int FA_N = 8,
    localparam int IDX_W = $clog2(WAYS * SETS + FA_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [PS_W-1:0]   glb_ps,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [VPPN_W-1:0] fill_vppn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_glb,
    input  logic [PS_W-1:0]   fill_ps,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx
);

    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int SET_W  = $clog2(SETS);
    localparam int FA_W   = (FA_N > 1) ? $clog2(FA_N) : 1;
    localparam int SA_ENT = WAYS * SETS;
    localparam int TOTAL  = SA_ENT + FA_N;

    tag_t             new_tag;
    logic             fill_sa, fill_fa, clr_sa, clr_fa;
    logic [SET_W-1:0] lk_set;
    logic [WAYS-1:0]  way_hit;
    logic [FA_N-1:0]  slot_hit;

    assign new_tag = '{vppn: fill_vppn, asid: fill_asid, glb: fill_glb};

    assign fill_sa = fill_en && (fill_idx < IDX_W'(SA_ENT));
    assign fill_fa = fill_en && !(fill_idx < IDX_W'(SA_ENT)) && (fill_idx < IDX_W'(TOTAL));
    assign clr_sa  = clr_en  && (clr_idx  < IDX_W'(SA_ENT));
    assign clr_fa  = clr_en  && !(clr_idx < IDX_W'(SA_ENT))  && (clr_idx  < IDX_W'(TOTAL));

    tlb_sa_bank #(.WAYS(WAYS), .SETS(SETS)) u_sa (
        .clk     (clk),
        .rst     (rst),
        .lk_va   (req_va),
        .lk_asid (req_asid),
        .glb_ps  (glb_ps),
        .wr_en   (fill_sa),
        .wr_way  (fill_idx[SET_W +: WAY_W]),
        .wr_set  (fill_idx[SET_W-1:0]),
        .wr_tag  (new_tag),
        .clr_en  (clr_sa),
        .clr_way (clr_idx[SET_W +: WAY_W]),
        .clr_set (clr_idx[SET_W-1:0]),
        .lk_set  (lk_set),
        .way_hit (way_hit)
    );

    tlb_fa_bank #(.FA_N(FA_N)) u_fa (
        .clk      (clk),
        .rst      (rst),
        .lk_va    (req_va),
        .lk_asid  (req_asid),
        .wr_en    (fill_fa),
        .wr_slot  (FA_W'(fill_idx - IDX_W'(SA_ENT))),
        .wr_tag   (new_tag),
        .wr_ps    (fill_ps),
        .clr_en   (clr_fa),
        .clr_slot (FA_W'(clr_idx - IDX_W'(SA_ENT))),
        .slot_hit (slot_hit)
    );

    tlb_pick #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .lk_set    (lk_set),
        .way_hit   (way_hit),
        .slot_hit  (slot_hit),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_idx   (rsp_idx)
    );

endmodule

// File: rtl/tlb_hybrid_chk.sv
module tlb_hybrid_chk
    import tlb_hyb_pkg::*;
#(
    parameter int WAYS = 8,
    parameter int SETS = 256,
    parameter int FA_N = 8,
    localparam int IDX_W = $clog2(WAYS * SETS + FA_N)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_va,
    input logic [PS_W-1:0]   glb_ps,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [IDX_W-1:0]  rsp_idx
);
    localparam int SET_W  = $clog2(SETS);
    localparam int SA_ENT = WAYS * SETS;
    localparam int TOTAL  = SA_ENT + FA_N;

    logic [SET_W-1:0] req_set;
    assign req_set = SET_W'(req_va >> ({1'b0, glb_ps} + 7'd1));

    a_r1_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r10_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);
    a_r10_miss_idx_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_idx == '0));
    a_r8_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_idx < IDX_W'(TOTAL)));
    a_r3_set_consistent: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ((rsp_hit && (rsp_idx < IDX_W'(SA_ENT))) ->
                       (rsp_idx[SET_W-1:0] == $past(req_set))));
endmodule

bind tlb_hybrid_lookup tlb_hybrid_chk #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_va    (req_va),
    .glb_ps    (glb_ps),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_idx   (rsp_idx)
);

// File: tb/sim_tlb_hybrid_lookup.sv
`timescale 1ns/1ps
module sim_tlb_hybrid_lookup;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [47:0] req_va;
    logic [9:0]  req_asid;
    logic [5:0]  glb_ps;
    logic        fill_en;
    logic [11:0] fill_idx;
    logic [34:0] fill_vppn;
    logic [9:0]  fill_asid;
    logic        fill_glb;
    logic [5:0]  fill_ps;
    logic        clr_en;
    logic [11:0] clr_idx;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [11:0] rsp_idx;

    always #2.5 clk = ~clk;

    tlb_hybrid_lookup u0 (.*);

    typedef struct {
        logic        hit;
        logic [11:0] idx;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   finished = 0;

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R1 unexpected response hit=%0d idx=%0d expected none", rsp_hit, rsp_idx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_hit !== e.hit || rsp_idx !== e.idx) begin
                    failures++;
                    $display("FAIL %s hit=%0d idx=%0d expected hit=%0d idx=%0d",
                             e.tag, rsp_hit, rsp_idx, e.hit, e.idx);
                end
            end
        end
    end

    task automatic look(input logic [47:0] va, input logic [9:0] asid,
                        input logic eh, input int ei, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        req_asid  = asid;
        @(posedge clk);
        e.hit = eh;
        e.idx = 12'(ei);
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(input int idx, input logic [47:0] va, input logic [9:0] asid,
                        input logic g, input logic [5:0] ps);
        @(negedge clk);
        fill_en   = 1'b1;
        fill_idx  = 12'(idx);
        fill_vppn = va[47:13];
        fill_asid = asid;
        fill_glb  = g;
        fill_ps   = ps;
        @(negedge clk);
        fill_en   = 1'b0;
    endtask

    task automatic clear(input int idx);
        @(negedge clk);
        clr_en  = 1'b1;
        clr_idx = 12'(idx);
        @(negedge clk);
        clr_en  = 1'b0;
    endtask

    localparam logic [47:0] VA_A = 48'h0000_4000_A000; // set 5 at ps 12
    localparam logic [47:0] VA_B = 48'h0000_5001_2000; // set 9 at ps 12
    localparam logic [47:0] VA_C = 48'h0001_2340_0000; // 4 MiB aligned
    localparam logic [47:0] VA_D = 48'h0000_6004_4000; // set 0x11 at ps 13

    initial begin
        rst = 1'b1; req_valid = 0; req_va = 0; req_asid = 0; glb_ps = 6'd12;
        fill_en = 0; fill_idx = 0; fill_vppn = 0; fill_asid = 0; fill_glb = 0; fill_ps = 0;
        clr_en = 0; clr_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_idx !== 12'd0) begin
            failures++;
            $display("FAIL R2 reset outputs valid=%0d hit=%0d idx=%0d expected 0 0 0",
                     rsp_valid, rsp_hit, rsp_idx);
        end
        look(VA_A, 10'd7, 0, 0, "R2 empty after reset");

        fill(3*256+5, VA_A, 10'd7, 1'b0, 6'd30);          // fill_ps ignored for SA
        look(VA_A, 10'd7, 1, 773, "R3/R8 set-assoc hit way3 set5");
        look(VA_A + 48'h1FFF, 10'd7, 1, 773, "R4 odd page of pair");
        look(VA_A, 10'd8, 0, 0, "R5 asid mismatch");
        look(VA_A + 48'h2000, 10'd7, 0, 0, "R10 next pair misses");

        fill(1*256+9, VA_B, 10'd3, 1'b1, 6'd12);
        look(VA_B, 10'd100, 1, 265, "R5 global ignores asid");

        fill(6*256+5, VA_A, 10'd7, 1'b0, 6'd12);
        look(VA_A, 10'd7, 1, 773, "R6 lower way wins");
        fill(5, VA_A, 10'd7, 1'b0, 6'd12);
        look(VA_A, 10'd7, 1, 5, "R6 way0 wins");
        clear(5);
        look(VA_A, 10'd7, 1, 773, "R9 cleared way0 skipped");

        fill(2050, VA_C, 10'd1, 1'b0, 6'd21);
        look(VA_C + 48'h3F_FFFF, 10'd1, 1, 2050, "R7 own page size top of pair");
        look(VA_C + 48'h40_0000, 10'd1, 0, 0, "R7 beyond large pair");

        fill(2048, VA_A, 10'd7, 1'b0, 6'd12);
        look(VA_A, 10'd7, 1, 773, "R6 set-assoc before full-assoc");
        clear(773);
        clear(6*256+5);
        look(VA_A, 10'd7, 1, 2048, "R6 full-assoc after clears");
        fill(2053, VA_A, 10'd7, 1'b0, 6'd12);
        look(VA_A, 10'd7, 1, 2048, "R6 lowest slot wins");

        glb_ps = 6'd13;
        look(VA_B, 10'd3, 0, 0, "R3 set moves with global size");
        look(VA_C + 48'h3F_FFFF, 10'd1, 1, 2050, "R7 global size has no effect");
        fill(2*256+17, VA_D, 10'd2, 1'b0, 6'd0);
        look(VA_D + 48'h2000, 10'd2, 1, 529, "R3/R4 pair at larger global size");

        glb_ps = 6'd12;
        clear(2050);
        look(VA_C, 10'd1, 0, 0, "R9 cleared slot misses");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R1 missing responses count=%0d expected 0", exp_q.size());
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired count=%0d expected done", 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule